// File: doc/BRIEF.md
# Seconds Counter with Match Interrupt

This peripheral keeps a 32-bit count of seconds. It sits on a simple word-addressed register bus with an address, a write strobe, write data and combinational read data. A one-cycle tick input, already in the bus clock domain, marks each second. Software can preload the count and start it with a sticky enable bit. It programs a match value and receives an interrupt when the count steps onto that value. The interrupt has a raw view, a masked view, a mask bit and a write-one-to-clear register. Four byte-wide identification words near the top of the address window give a part code and a designer code.

The register words are at these byte offsets:

| Offset | Register |
|--------|----------|
| 0x000 | Count |
| 0x004 | Match |
| 0x008 | Preload |
| 0x00C | Start |
| 0x010 | Mask |
| 0x014 | Raw status |
| 0x018 | Masked status |
| 0x01C | Clear |
| 0xFE0 to 0xFEC | Identification bytes |

Top module: `tick_clock_core`

## Requirements
- R1: A read at offset 0x000 returns the live counter value. A write to 0x000 leaves the counter unchanged.
- R2: Offset 0x004 holds the 32-bit match value. A read returns the last value written.
- R3: A write to offset 0x008 makes the counter take the written value on that clock edge. This load takes priority over a tick in the same cycle. A read of 0x008 returns the last value written, not the live count.
- R4: Bit 0 at offset 0x00C is the start bit. Writing 1 sets it. Once it is set, it stays 1 until reset whatever is written. A read returns it in bit 0. While it is 0, ticks do not change the counter.
- R5: On each tick while started, and with no load in that cycle, the counter increments by one. It wraps from 0xFFFFFFFF to 0.
- R6: The raw interrupt bit (bit 0 at offset 0x014) sets on a started tick that moves the counter onto the match value. It then stays set until it is cleared.
- R7: Writing 1 in bit 0 at offset 0x01C clears the raw bit, and writing 0 there has no effect. If a clear and a new match fall in the same cycle, the bit ends set. A read of 0x01C returns 0.
- R8: Bit 0 at offset 0x010 is the mask, read/write, with bits 31:1 reading 0. The irq output and bit 0 at offset 0x018 both equal the raw bit AND the mask.
- R9: Writes to offsets 0x014 and 0x018 change neither status bit.
- R10: Offsets 0xFE0, 0xFE4, 0xFE8 and 0xFEC each return one byte of an identification word. The lowest offset holds the least significant byte. The word is {config 8'h00, revision 4'h0, DESIGNER_CODE[7:0], PART_CODE[11:0]}.
- R11: Every register resets to zero. Unmapped offsets, and addresses whose two low bits are not zero, read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse per second |
| bus_addr_i | input | 12 | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Masked interrupt, active high |

## Verification
Two pairs of functions can act in the same cycle. A preload can meet a tick, and a clear can meet the tick that reaches the match value. The bench provokes each pair in a single bus cycle by raising the tick together with the write strobe. It then judges the result by reading the counter and the raw status. The counter must hold the loaded value and not its increment, and the raw bit must stay set despite the clear.

// File: rtl/tc_pkg.sv
package tc_pkg;

    // Word indices (byte offset >> 2) of the register window.
    localparam int unsigned WIX_COUNT  = 'h000;
    localparam int unsigned WIX_MATCH  = 'h001;
    localparam int unsigned WIX_PRELD  = 'h002;
    localparam int unsigned WIX_START  = 'h003;
    localparam int unsigned WIX_MASK   = 'h004;
    localparam int unsigned WIX_RAW    = 'h005;
    localparam int unsigned WIX_MSKD   = 'h006;
    localparam int unsigned WIX_CLEAR  = 'h007;
    localparam int unsigned WIX_ID0    = 'h3F8;
    localparam int unsigned ID_BYTES   = 4;

    // Identification word: config, revision, designer, part.
    function automatic logic [31:0] id_word(input logic [11:0] part,
                                            input logic [7:0]  designer);
        return {8'h00, 4'h0, designer, part};
    endfunction

endpackage

// File: rtl/tc_regs.sv
module tc_regs #(
    parameter int          ADDR_W        = 12,
    parameter int          DATA_W        = 32,
    parameter logic [11:0] PART_CODE     = 12'h7C2,
    parameter logic [7:0]  DESIGNER_CODE = 8'h9D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic [DATA_W-1:0] cnt_i,
    input  logic              raw_i,
    input  logic              irq_i,
    output logic [DATA_W-1:0] match_o,
    output logic              en_o,
    output logic              mask_o,
    output logic              load_fire_o,
    output logic              clr_fire_o,
    output logic [DATA_W-1:0] bus_rdata_o
);
    import tc_pkg::*;

    localparam int WORD_W = ADDR_W - 2;

    typedef struct packed {
        logic [DATA_W-1:0] match;
        logic [DATA_W-1:0] preload;
        logic              en;
        logic              mask;
    } regs_t;

    regs_t r_d, r_q;

    logic [WORD_W-1:0] widx;
    logic              aligned;
    logic              wr_ok;
    logic [31:0]       id_val;

    assign widx    = bus_addr_i[ADDR_W-1:2];
    assign aligned = (bus_addr_i[1:0] == 2'b00);
    assign wr_ok   = bus_wr_i && aligned;
    assign id_val  = id_word(PART_CODE, DESIGNER_CODE);

    // Next-state computation for all software-visible storage.
    always_comb begin
        r_d         = r_q;
        load_fire_o = 1'b0;
        clr_fire_o  = 1'b0;
        if (wr_ok) begin
            case (widx)
                WORD_W'(WIX_MATCH): r_d.match   = bus_wdata_i;
                WORD_W'(WIX_PRELD): begin
                    r_d.preload = bus_wdata_i;
                    load_fire_o = 1'b1;
                end
                WORD_W'(WIX_START): r_d.en      = r_q.en | bus_wdata_i[0];
                WORD_W'(WIX_MASK):  r_d.mask    = bus_wdata_i[0];
                WORD_W'(WIX_CLEAR): clr_fire_o  = bus_wdata_i[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign match_o = r_q.match;
    assign en_o    = r_q.en;
    assign mask_o  = r_q.mask;

    // Read multiplexer, combinational on the address.
    always_comb begin
        bus_rdata_o = '0;
        if (aligned) begin
            case (widx)
                WORD_W'(WIX_COUNT): bus_rdata_o = cnt_i;
                WORD_W'(WIX_MATCH): bus_rdata_o = r_q.match;
                WORD_W'(WIX_PRELD): bus_rdata_o = r_q.preload;
                WORD_W'(WIX_START): bus_rdata_o = DATA_W'(r_q.en);
                WORD_W'(WIX_MASK):  bus_rdata_o = DATA_W'(r_q.mask);
                WORD_W'(WIX_RAW):   bus_rdata_o = DATA_W'(raw_i);
                WORD_W'(WIX_MSKD):  bus_rdata_o = DATA_W'(irq_i);
                default: begin
                    for (int b = 0; b < ID_BYTES; b++) begin
                        if (widx == WORD_W'(WIX_ID0 + b))
                            bus_rdata_o = DATA_W'(id_val[8*b +: 8]);
                    end
                end
            endcase
        end
    end

    // R4
    start_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |=> en_o);

    // R2
    match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_i && bus_addr_i == ADDR_W'(WIX_MATCH << 2)) |=> $stable(match_o));

endmodule

// File: rtl/tc_counter.sv
module tc_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              en_i,
    input  logic              load_fire_i,
    input  logic [DATA_W-1:0] load_val_i,
    output logic [DATA_W-1:0] cnt_o,
    output logic [DATA_W-1:0] cnt_step_o,
    output logic              step_fire_o
);

    typedef struct packed {
        logic [DATA_W-1:0] cnt;
    } cnt_t;

    cnt_t c_d, c_q;

    always_comb begin
        c_d         = c_q;
        cnt_step_o  = c_q.cnt + DATA_W'(1);
        step_fire_o = tick_i && en_i && !load_fire_i;
        if (load_fire_i)      c_d.cnt = load_val_i;
        else if (step_fire_o) c_d.cnt = cnt_step_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt_o = c_q.cnt;

    // R3
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_fire_i |=> cnt_o == $past(load_val_i));

    // R5
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && en_i && !load_fire_i) |=> cnt_o == $past(cnt_o) + DATA_W'(1));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_fire_i) |=> $stable(cnt_o));

endmodule

// File: rtl/tc_irq.sv
module tc_irq #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_fire_i,
    input  logic [DATA_W-1:0] cnt_step_i,
    input  logic [DATA_W-1:0] match_i,
    input  logic              clr_fire_i,
    input  logic              mask_i,
    output logic              raw_o,
    output logic              irq_o
);

    typedef struct packed {
        logic raw;
    } irq_t;

    irq_t s_d, s_q;
    logic hit;

    always_comb begin
        s_d = s_q;
        hit = step_fire_i && (cnt_step_i == match_i);
        if (hit)             s_d.raw = 1'b1;
        else if (clr_fire_i) s_d.raw = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign raw_o = s_q.raw;
    assign irq_o = s_q.raw & mask_i;

    // R6
    raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_o && !clr_fire_i) |=> raw_o);

    // R7
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_fire_i && cnt_step_i == match_i && clr_fire_i) |=> raw_o);

    // R8
    irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (mask_i && raw_o));

endmodule

// File: rtl/tick_clock_core.sv
module tick_clock_core #(
    parameter int          ADDR_W        = 12,
    parameter int          DATA_W        = 32,
    parameter logic [11:0] PART_CODE     = 12'h7C2,
    parameter logic [7:0]  DESIGNER_CODE = 8'h9D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);

    logic [DATA_W-1:0] cnt, cnt_step, match;
    logic              en, mask, load_fire, clr_fire, step_fire, raw;

    tc_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .PART_CODE(PART_CODE), .DESIGNER_CODE(DESIGNER_CODE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_wdata_i(bus_wdata_i),
        .cnt_i(cnt), .raw_i(raw), .irq_i(irq_o),
        .match_o(match), .en_o(en), .mask_o(mask),
        .load_fire_o(load_fire), .clr_fire_o(clr_fire),
        .bus_rdata_o(bus_rdata_o)
    );

    tc_counter #(.DATA_W(DATA_W)) u_counter (
        .clk(clk), .rst_n(rst_n),
        .tick_i(tick_i), .en_i(en),
        .load_fire_i(load_fire), .load_val_i(bus_wdata_i),
        .cnt_o(cnt), .cnt_step_o(cnt_step), .step_fire_o(step_fire)
    );

    tc_irq #(.DATA_W(DATA_W)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .step_fire_i(step_fire), .cnt_step_i(cnt_step), .match_i(match),
        .clr_fire_i(clr_fire), .mask_i(mask),
        .raw_o(raw), .irq_o(irq_o)
    );

    // R9
    status_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_fire && !clr_fire) |=> $stable(raw));

endmodule

// File: tb/tick_clock_core_bench.sv
module tick_clock_core_bench;

    localparam logic [11:0] PART = 12'h7C2;
    localparam logic [7:0]  DES  = 8'h9D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [11:0] addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    tick_clock_core #(.PART_CODE(PART), .DESIGNER_CODE(DES)) u_tick_clock_core (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .bus_addr_i(addr), .bus_wr_i(wr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus cycle: optional write and optional tick, registered on one edge.
    task automatic cyc(input logic [11:0] a, input logic w, input logic [31:0] d, input logic t);
        @(negedge clk);
        addr = a; wr = w; wdata = d; tick = t;
        @(negedge clk);
        wr = 1'b0; tick = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic expect_rd(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic t_reset;
        expect_rd("R11 count reset", 12'h000, 32'h0);
        expect_rd("R11 start reset", 12'h00C, 32'h0);
        expect_rd("R11 raw reset",   12'h014, 32'h0);
        check("R11 irq reset", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_match_rw;
        cyc(12'h004, 1'b1, 32'h0000_0005, 1'b0);
        expect_rd("R2 match readback", 12'h004, 32'h5);
    endtask

    task automatic t_preload;
        cyc(12'h000, 1'b0, 32'h0, 1'b1);
        expect_rd("R4 no count while stopped", 12'h000, 32'h0);
        cyc(12'h008, 1'b1, 32'h0000_0100, 1'b0);
        expect_rd("R3 counter loaded", 12'h000, 32'h100);
        expect_rd("R3 preload readback", 12'h008, 32'h100);
        cyc(12'h000, 1'b1, 32'h0000_0055, 1'b0);
        expect_rd("R1 count write ignored", 12'h000, 32'h100);
    endtask

    task automatic t_start;
        cyc(12'h00C, 1'b1, 32'h1, 1'b0);
        expect_rd("R4 start reads one", 12'h00C, 32'h1);
        cyc(12'h00C, 1'b1, 32'h0, 1'b0);
        expect_rd("R4 start sticky", 12'h00C, 32'h1);
        cyc(12'h000, 1'b0, 32'h0, 1'b1);
        expect_rd("R5 increment", 12'h000, 32'h101);
        expect_rd("R3 preload not live", 12'h008, 32'h100);
    endtask

    task automatic t_load_vs_tick;
        cyc(12'h008, 1'b1, 32'h0000_2000, 1'b1);
        expect_rd("R3 load beats tick", 12'h000, 32'h2000);
    endtask

    task automatic t_wrap;
        cyc(12'h008, 1'b1, 32'hFFFF_FFFF, 1'b0);
        cyc(12'h000, 1'b0, 32'h0, 1'b1);
        expect_rd("R5 wrap", 12'h000, 32'h0);
        expect_rd("R6 no hit on wrap", 12'h014, 32'h0);
    endtask

    task automatic t_match_hit;
        cyc(12'h008, 1'b1, 32'h3, 1'b0);
        cyc(12'h000, 1'b0, 32'h0, 1'b1);
        expect_rd("R6 no early hit", 12'h014, 32'h0);
        cyc(12'h000, 1'b0, 32'h0, 1'b1);
        expect_rd("R6 raw set on reach", 12'h014, 32'h1);
        expect_rd("R8 masked zero", 12'h018, 32'h0);
        check("R8 irq masked off", {31'h0, irq}, 32'h0);
        cyc(12'h000, 1'b0, 32'h0, 1'b1);
        expect_rd("R6 raw stays", 12'h014, 32'h1);
    endtask

    task automatic t_mask;
        cyc(12'h010, 1'b1, 32'h1, 1'b0);
        expect_rd("R8 mask readback", 12'h010, 32'h1);
        check("R8 irq on", {31'h0, irq}, 32'h1);
        expect_rd("R8 masked one", 12'h018, 32'h1);
        cyc(12'h010, 1'b1, 32'hFFFF_FFFE, 1'b0);
        expect_rd("R8 mask upper zero", 12'h010, 32'h0);
        check("R8 irq off", {31'h0, irq}, 32'h0);
        cyc(12'h010, 1'b1, 32'h1, 1'b0);
    endtask

    task automatic t_status_ro;
        cyc(12'h014, 1'b1, 32'h0, 1'b0);
        cyc(12'h018, 1'b1, 32'h0, 1'b0);
        expect_rd("R9 raw unchanged", 12'h014, 32'h1);
        expect_rd("R9 masked unchanged", 12'h018, 32'h1);
    endtask

    task automatic t_clear;
        cyc(12'h01C, 1'b1, 32'hFFFF_FFFE, 1'b0);
        expect_rd("R7 clear zero no effect", 12'h014, 32'h1);
        cyc(12'h01C, 1'b1, 32'h1, 1'b0);
        expect_rd("R7 cleared", 12'h014, 32'h0);
        check("R7 irq drops", {31'h0, irq}, 32'h0);
        expect_rd("R7 clear reads zero", 12'h01C, 32'h0);
    endtask

    task automatic t_set_wins;
        cyc(12'h004, 1'b1, 32'd10, 1'b0);
        cyc(12'h008, 1'b1, 32'd9, 1'b0);
        cyc(12'h01C, 1'b1, 32'h1, 1'b1);
        expect_rd("R7 set wins", 12'h014, 32'h1);
        expect_rd("R5 count at match", 12'h000, 32'd10);
    endtask

    task automatic t_ident;
        expect_rd("R10 id byte0", 12'hFE0, {24'h0, PART[7:0]});
        expect_rd("R10 id byte1", 12'hFE4, {24'h0, DES[3:0], PART[11:8]});
        expect_rd("R10 id byte2", 12'hFE8, {24'h0, 4'h0, DES[7:4]});
        expect_rd("R10 id byte3", 12'hFEC, 32'h0);
    endtask

    task automatic t_unmapped;
        expect_rd("R11 unmapped 0x020", 12'h020, 32'h0);
        expect_rd("R11 unmapped 0x800", 12'h800, 32'h0);
        expect_rd("R11 misaligned", 12'h001, 32'h0);
    endtask

    initial begin
        #200_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_match_rw();
        t_preload();
        t_start();
        t_load_vs_tick();
        t_wrap();
        t_match_hit();
        t_mask();
        t_status_ro();
        t_clear();
        t_set_wins();
        t_ident();
        t_unmapped();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule